// File: doc/BRIEF.md
# Fixed-Point Status Flag Update Unit

This block works out the next state of the five fixed-point status bits for one retired result. The bits are sticky overflow, overflow, carry, 32-bit overflow and 32-bit carry. It does not compute any result itself. The adder, multiplier, divider and shifter supply their operands and raw outputs. The block combines them with the instruction class, the overflow-enable bit, the 64/32-bit mode and the current flag values.

Each flag leaves the block with its own write strobe. A dependency tracker or rename stage can therefore treat every bit as an independent register. A flag whose strobe is low is passed through unchanged. Setting `REG_OUT` to 1 adds one pipeline register on all outputs, which resets to zero. Setting it to 0 makes the block purely combinational.

Top module: `xflag_update`

## Requirements
- R1: Class codes on `op_i` are: 0 add/subtract-from/negate, 1 carrying add/subtract, 2 extended add/subtract, 3 multiply, 4 signed divide, 5 arithmetic shift right, 6 compare, 7 logical, 8 move-to-status-register. For compare and logical, every write strobe is 0 and every flag output equals its input.
- R2: For class 0 with `oe_i`=1, overflow is the XOR of the carry into and the carry out of the top bit. The top bit is bit 63 when `mode64_i`=1 and bit 31 otherwise. OV32 always uses bit 31. Carry is not written. With `oe_i`=0, nothing is written.
- R3: Class 1 writes CA with `sum_i[64]` in 64-bit mode, or with the carry out of bit 31 in 32-bit mode. It writes CA32 with the carry out of bit 31. Overflow follows R2 under `oe_i`.
- R4: For class 2 with `ext_sel_i`=1, CA and CA32 are written as in R3 and overflow is untouched. With `ext_sel_i`=0, OV takes the carry out of the selected width, OV32 takes the carry out of bit 31, and CA and CA32 are untouched.
- R5: For class 3 with `oe_i`=1, OV is set when the signed product in `prod_i` does not fit the destination. The destination is 64 bits in 64-bit mode and 32 bits in 32-bit mode. OV32 is always judged against 32 bits, using `prod_i[63:0]`.
- R6: For class 4 with `oe_i`=1, OV is set on a zero divisor, or on the most negative dividend divided by -1, at the selected width. OV32 applies the same test to the low 32 bits.
- R7: For class 5, CA is 1 only when the operand is negative and a 1 bit is shifted out. The operand and shift amount are `a_i`/`b_i[6:0]` in 64-bit mode, where 64 or more shifts out everything. In 32-bit mode they are `a_i[31:0]`/`b_i[5:0]`, where 32 or more shifts out everything. CA32 equals CA. Overflow is not written.
- R8: Class 8 writes all five flags from `a_i`: sticky overflow from bit 31, OV from 30, CA from 29, OV32 from 19 and CA32 from 18.
- R9: Whenever OV is written outside class 8, sticky overflow is also written as its old value ORed with the new OV. It is never cleared except by class 8.
- R10: When a write strobe is low, the matching flag output equals the incoming flag value.
- R11: With `REG_OUT`=1, all outputs reflect the inputs of the previous clock edge, and they are 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (used when REG_OUT=1) |
| rst_n | input | 1 | Active-low synchronous reset of the output register |
| op_i | input | 4 | Instruction class code |
| oe_i | input | 1 | Overflow-enable bit of the instruction |
| mode64_i | input | 1 | 1 = 64-bit mode, 0 = 32-bit mode |
| ext_sel_i | input | 1 | Extended-add carry field: 1 = CA, 0 = OV |
| a_i | input | 64 | First adder input (already inverted for subtract-from), dividend, shift source or move source |
| b_i | input | 64 | Second adder input, divisor or shift amount |
| sum_i | input | 65 | Adder sum with carry out in bit 64 |
| prod_i | input | 128 | Signed full product |
| so_i | input | 1 | Current sticky overflow |
| ov_i | input | 1 | Current overflow |
| ca_i | input | 1 | Current carry |
| ov32_i | input | 1 | Current 32-bit overflow |
| ca32_i | input | 1 | Current 32-bit carry |
| so_o | output | 1 | Next sticky overflow |
| ov_o | output | 1 | Next overflow |
| ca_o | output | 1 | Next carry |
| ov32_o | output | 1 | Next 32-bit overflow |
| ca32_o | output | 1 | Next 32-bit carry |
| so_we_o | output | 1 | Sticky overflow write strobe |
| ov_we_o | output | 1 | Overflow write strobe |
| ca_we_o | output | 1 | Carry write strobe |
| ov32_we_o | output | 1 | 32-bit overflow write strobe |
| ca32_we_o | output | 1 | 32-bit carry write strobe |

## Verification
The assertions take for granted that `sum_i` really is `a_i + b_i` plus some carry-in. Carries into a bit are recovered from that relation. They also assume `prod_i` is the sign-extended product of the operands, and that `op_i` never carries a code above 8.

The stimulus keeps to this contract. The bench forms every sum and product itself from random operands before driving them, and it draws the class only from the nine legal codes. Operands for multiply and divide are shrunk or forced to zero, the most negative value and -1. This makes both outcomes of the fit test occur.

// File: rtl/xflag_pkg.sv
package xflag_pkg;

    typedef enum logic [3:0] {
        XOP_ADD   = 4'd0,
        XOP_ADDC  = 4'd1,
        XOP_EXT   = 4'd2,
        XOP_MUL   = 4'd3,
        XOP_DIV   = 4'd4,
        XOP_SRA   = 4'd5,
        XOP_CMP   = 4'd6,
        XOP_LOGIC = 4'd7,
        XOP_MTX   = 4'd8
    } xop_e;

    // bit positions of the flags inside a move-to-status-register source
    localparam int unsigned XB_SO   = 31;
    localparam int unsigned XB_OV   = 30;
    localparam int unsigned XB_CA   = 29;
    localparam int unsigned XB_OV32 = 19;
    localparam int unsigned XB_CA32 = 18;

    typedef struct packed {
        logic so;
        logic ov;
        logic ca;
        logic ov32;
        logic ca32;
    } xflag_bits_t;

    typedef struct packed {
        xflag_bits_t we;
        xflag_bits_t val;
    } xflag_upd_t;

endpackage

// File: rtl/xflag_addflags.sv
module xflag_addflags #(
    parameter int unsigned XLEN = 64,
    parameter int unsigned HALF = 32
) (
    input  logic [XLEN-1:0] a_i,
    input  logic [XLEN-1:0] b_i,
    input  logic [XLEN:0]   sum_i,
    output logic            co_full_o,
    output logic            co_half_o,
    output logic            ov_full_o,
    output logic            ov_half_o
);
    logic cin_full_top;
    logic cin_half_top;

    always_comb begin
        // carry into bit k is recovered from the sum and both addends
        cin_full_top = sum_i[XLEN-1] ^ a_i[XLEN-1] ^ b_i[XLEN-1];
        cin_half_top = sum_i[HALF-1] ^ a_i[HALF-1] ^ b_i[HALF-1];
        co_full_o    = sum_i[XLEN];
        co_half_o    = sum_i[HALF] ^ a_i[HALF] ^ b_i[HALF];
        ov_full_o    = co_full_o ^ cin_full_top;
        ov_half_o    = co_half_o ^ cin_half_top;
    end
endmodule

// File: rtl/xflag_fitcheck.sv
module xflag_fitcheck #(
    parameter int unsigned XLEN = 64,
    parameter int unsigned HALF = 32,
    localparam int unsigned WIDE = 2 * XLEN
) (
    input  logic [WIDE-1:0] prod_i,
    input  logic [XLEN-1:0] dvd_i,
    input  logic [XLEN-1:0] dvs_i,
    output logic            mul_full_o,
    output logic            mul_half_o,
    output logic            div_full_o,
    output logic            div_half_o
);
    logic [XLEN:0] hi_full;
    logic [XLEN-HALF:0] hi_half;
    logic [XLEN-1:0] min_full;
    logic [HALF-1:0] min_half;

    always_comb begin
        hi_full  = prod_i[WIDE-1:XLEN-1];
        hi_half  = prod_i[XLEN-1:HALF-1];
        min_full = {1'b1, {(XLEN-1){1'b0}}};
        min_half = {1'b1, {(HALF-1){1'b0}}};
        // a product fits when every bit above the sign position copies it
        mul_full_o = !((&hi_full) || !(|hi_full));
        mul_half_o = !((&hi_half) || !(|hi_half));
        div_full_o = (dvs_i == '0) || ((dvd_i == min_full) && (&dvs_i));
        div_half_o = (dvs_i[HALF-1:0] == '0)
                  || ((dvd_i[HALF-1:0] == min_half) && (&dvs_i[HALF-1:0]));
    end
endmodule

// File: rtl/xflag_sracarry.sv
module xflag_sracarry #(
    parameter int unsigned XLEN = 64,
    parameter int unsigned HALF = 32,
    localparam int unsigned SH_W = $clog2(XLEN) + 1,
    localparam int unsigned SH_H = $clog2(HALF) + 1
) (
    input  logic [XLEN-1:0] src_i,
    input  logic [SH_W-1:0] amt_i,
    output logic            ca_full_o,
    output logic            ca_half_o
);
    logic lost_full;
    logic lost_half;
    logic [SH_H-1:0] amt_h;

    always_comb begin
        amt_h     = amt_i[SH_H-1:0];
        lost_full = 1'b0;
        lost_half = 1'b0;
        for (int i = 0; i < XLEN; i++) begin
            if (SH_W'(i) < amt_i) lost_full = lost_full | src_i[i];
        end
        for (int j = 0; j < HALF; j++) begin
            if (SH_H'(j) < amt_h) lost_half = lost_half | src_i[j];
        end
        ca_full_o = src_i[XLEN-1] & lost_full;
        ca_half_o = src_i[HALF-1] & lost_half;
    end
endmodule

// File: rtl/xflag_update.sv
module xflag_update
    import xflag_pkg::*;
#(
    parameter int unsigned XLEN    = 64,
    parameter int unsigned HALF    = 32,
    parameter bit          REG_OUT = 1'b1,
    localparam int unsigned WIDE   = 2 * XLEN,
    localparam int unsigned SH_W   = $clog2(XLEN) + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [3:0]      op_i,
    input  logic            oe_i,
    input  logic            mode64_i,
    input  logic            ext_sel_i,
    input  logic [XLEN-1:0] a_i,
    input  logic [XLEN-1:0] b_i,
    input  logic [XLEN:0]   sum_i,
    input  logic [WIDE-1:0] prod_i,
    input  logic            so_i,
    input  logic            ov_i,
    input  logic            ca_i,
    input  logic            ov32_i,
    input  logic            ca32_i,
    output logic            so_o,
    output logic            ov_o,
    output logic            ca_o,
    output logic            ov32_o,
    output logic            ca32_o,
    output logic            so_we_o,
    output logic            ov_we_o,
    output logic            ca_we_o,
    output logic            ov32_we_o,
    output logic            ca32_we_o
);
    logic co_full, co_half, aov_full, aov_half;
    logic mov_full, mov_half, dov_full, dov_half;
    logic sca_full, sca_half;
    xflag_upd_t upd_d, upd_q, upd_out;
    xop_e op;

    xflag_addflags #(.XLEN(XLEN), .HALF(HALF)) i_add (
        .a_i(a_i), .b_i(b_i), .sum_i(sum_i),
        .co_full_o(co_full), .co_half_o(co_half),
        .ov_full_o(aov_full), .ov_half_o(aov_half)
    );

    xflag_fitcheck #(.XLEN(XLEN), .HALF(HALF)) i_fit (
        .prod_i(prod_i), .dvd_i(a_i), .dvs_i(b_i),
        .mul_full_o(mov_full), .mul_half_o(mov_half),
        .div_full_o(dov_full), .div_half_o(dov_half)
    );

    xflag_sracarry #(.XLEN(XLEN), .HALF(HALF)) i_sra (
        .src_i(a_i), .amt_i(b_i[SH_W-1:0]),
        .ca_full_o(sca_full), .ca_half_o(sca_half)
    );

    always_comb begin
        op = xop_e'(op_i);
        upd_d.we       = '0;
        upd_d.val.so   = so_i;
        upd_d.val.ov   = ov_i;
        upd_d.val.ca   = ca_i;
        upd_d.val.ov32 = ov32_i;
        upd_d.val.ca32 = ca32_i;
        unique case (op)
            XOP_ADD, XOP_ADDC: begin
                if (oe_i) begin
                    upd_d.we.ov   = 1'b1;
                    upd_d.we.ov32 = 1'b1;
                    upd_d.val.ov   = mode64_i ? aov_full : aov_half;
                    upd_d.val.ov32 = aov_half;
                end
                if (op == XOP_ADDC) begin
                    upd_d.we.ca   = 1'b1;
                    upd_d.we.ca32 = 1'b1;
                    upd_d.val.ca   = mode64_i ? co_full : co_half;
                    upd_d.val.ca32 = co_half;
                end
            end
            XOP_EXT: begin
                if (ext_sel_i) begin
                    upd_d.we.ca   = 1'b1;
                    upd_d.we.ca32 = 1'b1;
                    upd_d.val.ca   = mode64_i ? co_full : co_half;
                    upd_d.val.ca32 = co_half;
                end else begin
                    upd_d.we.ov   = 1'b1;
                    upd_d.we.ov32 = 1'b1;
                    upd_d.val.ov   = mode64_i ? co_full : co_half;
                    upd_d.val.ov32 = co_half;
                end
            end
            XOP_MUL: begin
                if (oe_i) begin
                    upd_d.we.ov   = 1'b1;
                    upd_d.we.ov32 = 1'b1;
                    upd_d.val.ov   = mode64_i ? mov_full : mov_half;
                    upd_d.val.ov32 = mov_half;
                end
            end
            XOP_DIV: begin
                if (oe_i) begin
                    upd_d.we.ov   = 1'b1;
                    upd_d.we.ov32 = 1'b1;
                    upd_d.val.ov   = mode64_i ? dov_full : dov_half;
                    upd_d.val.ov32 = dov_half;
                end
            end
            XOP_SRA: begin
                upd_d.we.ca   = 1'b1;
                upd_d.we.ca32 = 1'b1;
                upd_d.val.ca   = mode64_i ? sca_full : sca_half;
                upd_d.val.ca32 = mode64_i ? sca_full : sca_half;
            end
            XOP_MTX: begin
                upd_d.we       = '1;
                upd_d.val.so   = a_i[XB_SO];
                upd_d.val.ov   = a_i[XB_OV];
                upd_d.val.ca   = a_i[XB_CA];
                upd_d.val.ov32 = a_i[XB_OV32];
                upd_d.val.ca32 = a_i[XB_CA32];
            end
            default: ;
        endcase
        // sticky overflow accumulates every overflow write (R9)
        if (upd_d.we.ov && (op != XOP_MTX)) begin
            upd_d.we.so  = 1'b1;
            upd_d.val.so = so_i | upd_d.val.ov;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) upd_q <= '0;
        else        upd_q <= upd_d;
    end

    generate
        if (REG_OUT) begin : g_reg
            assign upd_out = upd_q;
            // R11: registered outputs present the previous cycle's update
            p_reg_latency_r11: assert property (@(posedge clk) disable iff (!rst_n)
                rst_n |=> ({so_o, ov_o, ca_o, ov32_o, ca32_o} == $past(upd_d.val)));
            p_reg_strobes_r11: assert property (@(posedge clk) disable iff (!rst_n)
                rst_n |=> ({so_we_o, ov_we_o, ca_we_o, ov32_we_o, ca32_we_o} == $past(upd_d.we)));
        end else begin : g_comb
            assign upd_out = upd_d;
        end
    endgenerate

    assign so_o      = upd_out.val.so;
    assign ov_o      = upd_out.val.ov;
    assign ca_o      = upd_out.val.ca;
    assign ov32_o    = upd_out.val.ov32;
    assign ca32_o    = upd_out.val.ca32;
    assign so_we_o   = upd_out.we.so;
    assign ov_we_o   = upd_out.we.ov;
    assign ca_we_o   = upd_out.we.ca;
    assign ov32_we_o = upd_out.we.ov32;
    assign ca32_we_o = upd_out.we.ca32;

    // R1: compare and logical classes never raise a strobe
    p_quiet_classes_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ((op_i == 4'd6) || (op_i == 4'd7)) |-> (upd_d.we == '0));
    // R9: sticky overflow never drops outside a move
    p_so_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (so_i && (op_i != 4'd8)) |-> upd_d.val.so);
    // R9: an overflow written as 1 outside a move also marks sticky overflow
    p_ov_marks_so_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_d.we.ov && upd_d.val.ov && (op_i != 4'd8)) |-> (upd_d.we.so && upd_d.val.so));
    // R10: unwritten carry passes through
    p_ca_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_d.we.ca |-> (upd_d.val.ca == ca_i));
    // R7: shifts never touch overflow
    p_sra_no_ov_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 4'd5) |-> !(upd_d.we.ov || upd_d.we.so));
    // R4: the extended add writes exactly one of the two carry fields
    p_ext_one_field_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 4'd2) |-> (upd_d.we.ov ^ upd_d.we.ca));
endmodule

// File: tb/test_xflag_update.sv
module test_xflag_update;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [3:0] op;
    logic oe, m64, esel;
    logic [63:0] a, b;
    logic [64:0] sum;
    logic [127:0] prod;
    logic [4:0] cur;
    logic so_o, ov_o, ca_o, ov32_o, ca32_o;
    logic so_we, ov_we, ca_we, ov32_we, ca32_we;
    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    xflag_update i_xflag_update (
        .clk(clk), .rst_n(rst_n), .op_i(op), .oe_i(oe), .mode64_i(m64),
        .ext_sel_i(esel), .a_i(a), .b_i(b), .sum_i(sum), .prod_i(prod),
        .so_i(cur[4]), .ov_i(cur[3]), .ca_i(cur[2]), .ov32_i(cur[1]), .ca32_i(cur[0]),
        .so_o(so_o), .ov_o(ov_o), .ca_o(ca_o), .ov32_o(ov32_o), .ca32_o(ca32_o),
        .so_we_o(so_we), .ov_we_o(ov_we), .ca_we_o(ca_we),
        .ov32_we_o(ov32_we), .ca32_we_o(ca32_we)
    );

    // expected {strobes, values}, order so ov ca ov32 ca32
    function automatic logic [9:0] model(input logic [3:0] o, input logic e, input logic md,
                                         input logic es, input logic [63:0] x, input logic [63:0] y,
                                         input logic [64:0] s, input logic [127:0] p,
                                         input logic [4:0] c);
        logic [4:0] we = 5'b0;
        logic [4:0] v = c;
        logic sov64 = (x[63] == y[63]) && (s[63] != x[63]);
        logic sov32 = (x[31] == y[31]) && (s[31] != x[31]);
        logic [32:0] low = {1'b0, x[31:0]} + {1'b0, y[31:0]} + {32'd0, s[0] ^ x[0] ^ y[0]};
        logic c32 = low[32];
        logic cw = md ? s[64] : c32;
        logic m64ov = ($signed(p) > $signed({64'd0, 64'h7fff_ffff_ffff_ffff}))
                   || ($signed(p) < $signed({{64{1'b1}}, 64'h8000_0000_0000_0000}));
        logic m32ov = ($signed(p[63:0]) > 64'sh7fff_ffff) || ($signed(p[63:0]) < -64'sh8000_0000);
        logic d64ov = (y == 64'd0) || (x == 64'h8000_0000_0000_0000 && y == '1);
        logic d32ov = (y[31:0] == 32'd0) || (x[31:0] == 32'h8000_0000 && y[31:0] == '1);
        logic sca;
        int sh;
        if (md) begin
            sh = int'(y[6:0]);
            sca = x[63] && ((sh >= 64) ? (x != 0) : ((x & ~({64{1'b1}} << sh)) != 0));
        end else begin
            sh = int'(y[5:0]);
            sca = x[31] && ((sh >= 32) ? (x[31:0] != 0)
                                       : ((x[31:0] & ~({32{1'b1}} << sh)) != 0));
        end
        case (o)
            4'd0, 4'd1: begin
                if (e) begin we[3] = 1; we[1] = 1; v[3] = md ? sov64 : sov32; v[1] = sov32; end
                if (o == 4'd1) begin we[2] = 1; we[0] = 1; v[2] = cw; v[0] = c32; end
            end
            4'd2: if (es) begin we[2] = 1; we[0] = 1; v[2] = cw; v[0] = c32; end
                  else begin we[3] = 1; we[1] = 1; v[3] = cw; v[1] = c32; end
            4'd3: if (e) begin we[3] = 1; we[1] = 1; v[3] = md ? m64ov : m32ov; v[1] = m32ov; end
            4'd4: if (e) begin we[3] = 1; we[1] = 1; v[3] = md ? d64ov : d32ov; v[1] = d32ov; end
            4'd5: begin we[2] = 1; we[0] = 1; v[2] = sca; v[0] = sca; end
            4'd8: begin we = 5'b11111; v = {x[31], x[30], x[29], x[19], x[18]}; end
            default: ;
        endcase
        if (we[3] && o != 4'd8) begin we[4] = 1; v[4] = c[4] | v[3]; end
        return {we, v};
    endfunction

    function automatic string tag(input logic [3:0] o);
        case (o)
            4'd0: return "R2/R9/R10";
            4'd1: return "R3/R9/R10";
            4'd2: return "R4/R9/R10";
            4'd3: return "R5/R9/R10";
            4'd4: return "R6/R9/R10";
            4'd5: return "R7/R10";
            4'd8: return "R8";
            default: return "R1/R10";
        endcase
    endfunction

    function automatic logic [9:0] got();
        return {so_we, ov_we, ca_we, ov32_we, ca32_we, so_o, ov_o, ca_o, ov32_o, ca32_o};
    endfunction

    task automatic check(input string req, input logic [9:0] act, input logic [9:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s op=%0d act=%b exp=%b", req, op, act, exp);
        end
    endtask

    // drive one vector, let it pass the output register, compare (R11 latency)
    task automatic apply(input logic [3:0] o, input logic e, input logic md, input logic es,
                         input logic [63:0] x, input logic [63:0] y, input logic cin,
                         input logic [4:0] c);
        logic [9:0] exp;
        logic signed [127:0] sx, sy;
        op = o; oe = e; m64 = md; esel = es; a = x; b = y; cur = c;
        sum = {1'b0, x} + {1'b0, y} + {64'd0, cin};
        if (md) begin
            sx = $signed({{64{x[63]}}, x}); sy = $signed({{64{y[63]}}, y});
        end else begin
            sx = $signed({{96{x[31]}}, x[31:0]}); sy = $signed({{96{y[31]}}, y[31:0]});
        end
        prod = sx * sy;
        exp = model(o, e, md, es, x, y, sum, prod, c);
        @(posedge clk);
        @(negedge clk);
        check(tag(o), got(), exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [63:0] x, y;
        void'($urandom(32'd20240611));
        op = 4'd6; oe = 0; m64 = 1; esel = 0; a = '1; b = '1; sum = '1; prod = '1; cur = '1;
        repeat (3) @(negedge clk);
        check("R11 reset", got(), 10'd0);
        rst_n = 1'b1;
        // directed corners
        apply(4'd0, 1, 1, 0, 64'h7fff_ffff_ffff_ffff, 64'd1, 0, 5'b00000);
        check("R9 sticky set", {so_we, so_o}, 2'b11);
        apply(4'd0, 1, 0, 0, 64'h0000_0000_7fff_ffff, 64'd1, 0, 5'b00000);
        apply(4'd0, 0, 1, 0, 64'h7fff_ffff_ffff_ffff, 64'd1, 0, 5'b01010);
        apply(4'd0, 1, 1, 0, 64'd5, 64'd6, 0, 5'b10000);
        check("R9 sticky kept", so_o, 1'b1);
        apply(4'd1, 0, 1, 0, 64'hffff_ffff_ffff_ffff, 64'd1, 0, 5'b00000);
        apply(4'd1, 0, 0, 0, 64'h0000_0000_ffff_ffff, 64'd1, 0, 5'b00000);
        apply(4'd2, 0, 1, 1, 64'hffff_ffff_ffff_ffff, 64'd0, 1, 5'b00000);
        apply(4'd2, 0, 1, 0, 64'hffff_ffff_ffff_ffff, 64'd0, 1, 5'b00100);
        apply(4'd3, 1, 1, 0, 64'h0000_0001_0000_0000, 64'h0000_0001_0000_0000, 0, 5'b0);
        apply(4'd3, 1, 0, 0, 64'h0000_0000_0001_0000, 64'h0000_0000_0000_8000, 0, 5'b0);
        apply(4'd4, 1, 1, 0, 64'h8000_0000_0000_0000, 64'hffff_ffff_ffff_ffff, 0, 5'b0);
        apply(4'd4, 1, 0, 0, 64'd7, 64'hffff_ffff_0000_0000, 0, 5'b0);
        apply(4'd4, 1, 1, 0, 64'd7, 64'hffff_ffff_0000_0000, 0, 5'b0);
        apply(4'd5, 0, 1, 0, 64'h8000_0000_0000_0001, 64'd1, 0, 5'b0);
        apply(4'd5, 0, 1, 0, 64'h8000_0000_0000_0000, 64'd63, 0, 5'b0);
        apply(4'd5, 0, 1, 0, 64'h8000_0000_0000_0000, 64'd64, 0, 5'b0);
        apply(4'd5, 0, 0, 0, 64'h0000_0000_8000_0004, 64'd2, 0, 5'b0);
        apply(4'd5, 0, 0, 0, 64'h0000_0000_8000_0004, 64'd3, 0, 5'b0);
        apply(4'd5, 0, 1, 0, 64'h7fff_ffff_ffff_ffff, 64'd127, 0, 5'b0);
        apply(4'd6, 1, 1, 0, 64'h7fff_ffff_ffff_ffff, 64'd1, 0, 5'b10101);
        apply(4'd7, 1, 1, 1, 64'hffff_ffff_ffff_ffff, 64'd1, 1, 5'b01010);
        apply(4'd8, 0, 1, 0, 64'h0000_0000_a008_0000, 64'd0, 0, 5'b11111);
        apply(4'd8, 0, 0, 0, 64'h0000_0000_4004_0000, 64'd0, 0, 5'b00000);
        // constrained random
        for (int n = 0; n < 3000; n++) begin
            logic [3:0] o = 4'($urandom % 9);
            x = {$urandom, $urandom};
            y = {$urandom, $urandom};
            if (o == 4'd3) begin
                x = 64'($signed(x) >>> ($urandom % 64));
                y = 64'($signed(y) >>> ($urandom % 64));
            end
            if (o == 4'd4) begin
                case ($urandom % 4)
                    0: y = '0;
                    1: begin x = 64'h8000_0000_0000_0000; y = '1; end
                    2: begin x[31:0] = 32'h8000_0000; y[31:0] = '1; end
                    default: ;
                endcase
            end
            if (o == 4'd5) y = {57'd0, 7'($urandom)};
            apply(o, 1'($urandom), 1'($urandom), 1'($urandom), x, y, 1'($urandom),
                  5'($urandom));
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule